// File: doc/BRIEF.md
# Integer ALU with Signed-Count Shifter

This block is the integer execution stage of a 32-bit signal-processing datapath. Each accepted operation takes an opcode, a form select and up to three operand values, plus the carry bit of the status register. It returns one result word and four condition flags: negative, zero, carry and overflow. The operations are absolute value, add, add with carry-in, bitwise AND, AND with the complemented operand, and an arithmetic shift. The shift direction follows the sign of a shift count.

Two-operand and three-operand forms share one datapath. Only the routing of operands into it differs. In the two-operand form the current destination value is the first input. In the three-operand form two independent sources feed the unit. The arithmetic is combinational. The result and flags are captured in a register when the input strobe is high, and an output strobe follows one cycle later.

Top module: `ialu_core`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. Result and flags change only on accepted operations and otherwise keep their last value.
- R2: With `three_op`=0, operand A is `dst_val` and operand B is `src_a`. With `three_op`=1, operand A is `src_a` and operand B is `src_b`.
- R3: Opcode 0 (absolute value) returns the magnitude of operand B with C=0. For B=0x80000000 it returns 0x80000000 with V=1. Otherwise V=0.
- R4: Opcode 1 (add) returns A+B modulo 2^32. C is the unsigned carry out of bit 31, and V is the two's-complement overflow.
- R5: Opcode 2 (add with carry) returns A+B+`carry_in`. C and V follow the same rules as in R4.
- R6: Opcode 3 returns A AND B, and opcode 4 returns A AND (NOT B). Both clear C and V.
- R7: Opcode 5 (shift) takes the count from B[6:0] as a signed value. A count of zero or more shifts A left. A negative count shifts A right arithmetically by the magnitude of the count. Left counts of 32 or more give 0. Right magnitudes of 32 or more give 32 copies of A[31]. V is 0.
- R8: The shift carry is the last bit shifted out, and it is 0 for a count of zero. For a left count above 32 the carry is 0. For a right magnitude above 32 the carry is A[31].
- R9: For every opcode, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R10: Opcodes 6 and 7 return 0 with Z=1 and N, C and V all 0.
- R11: While `rst` is high and after its release, `out_valid`, the result and all flags are 0 until the first accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operation on this edge |
| op_code | input | 3 | Operation select |
| three_op | input | 1 | 1 = three-operand routing |
| dst_val | input | 32 | Current destination value (two-operand form) |
| src_a | input | 32 | Source (two-operand form) or first source |
| src_b | input | 32 | Second source (three-operand form) |
| carry_in | input | 1 | Status-register carry bit |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 32 | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Every result and flag is due one clock edge after the edge that sees `in_valid` high, together with `out_valid`. The bench drives each operation on a falling edge and holds the strobe for one cycle. It compares the outputs on the next falling edge, half a cycle after the capturing edge. Idle cycles are then sampled the same way, to confirm that `out_valid` has dropped and the registered values have not moved.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ABS   = 3'd0,
    OP_ADD   = 3'd1,
    OP_ADDC  = 3'd2,
    OP_AND   = 3'd3,
    OP_ANDN  = 3'd4,
    OP_SHIFT = 3'd5
  } op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/ialu_arith.sv
module ialu_arith #(
  parameter int W = 32
) (
  input  logic         do_abs,
  input  logic         use_carry,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  logic [W:0]   sum;
  logic         add_v;
  logic [W-1:0] mag;
  logic         abs_v;

  always_comb begin
    sum   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, (use_carry & cin)};
    add_v = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    mag   = b[W-1] ? (~b + {{(W-1){1'b0}}, 1'b1}) : b;
    abs_v = b[W-1] && (b[W-2:0] == '0);
    if (do_abs) begin
      res  = mag;
      cout = 1'b0;
      ovf  = abs_v;
    end else begin
      res  = sum[W-1:0];
      cout = sum[W];
      ovf  = add_v;
    end
  end

  // R3: a magnitude without overflow is never negative
  always_comb begin
    if (do_abs && !ovf)
      assert_abs_sign_R3: assert (!res[W-1]);
  end
endmodule

// File: rtl/ialu_logic.sv
module ialu_logic #(
  parameter int W = 32
) (
  input  logic         invert_b,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb res = a & (invert_b ? ~b : b);
endmodule

// File: rtl/ialu_shift.sv
module ialu_shift #(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input  logic [W-1:0]  val,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  res,
  output logic          cout
);
  localparam int LW = 2 * W;
  localparam int RW = 2 * W + 1;

  logic          go_right;
  logic [CW-1:0] mag;
  logic [LW-1:0] lext;
  logic signed [RW-1:0] rext;

  always_comb begin
    go_right = cnt[CW-1];
    mag      = go_right ? (~cnt + {{(CW-1){1'b0}}, 1'b1}) : cnt;
    lext     = {{W{1'b0}}, val} << mag;
    rext     = $signed({{W{val[W-1]}}, val, 1'b0}) >>> mag;
    if (go_right) begin
      res  = rext[W:1];
      cout = rext[0];
    end else begin
      res  = lext[W-1:0];
      cout = lext[W];
    end
  end

  // R8: a zero count passes the value through with no carry
  always_comb begin
    if (cnt == '0)
      assert_zero_count_R8: assert (res == val && !cout);
  end
endmodule

// File: rtl/ialu_core.sv
module ialu_core #(
  parameter int W  = 32,
  parameter int CW = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op_code,
  input  logic         three_op,
  input  logic [W-1:0] dst_val,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v
);
  import ialu_pkg::*;

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] opa, opb;
  logic [W-1:0] ar_res, lg_res, sh_res, nxt_res;
  logic         ar_c, ar_v, sh_c;
  flags_t       nxt_f;

  assign opa = three_op ? src_a : dst_val;
  assign opb = three_op ? src_b : src_a;

  ialu_arith #(.W(W)) u_arith (
    .do_abs    (op_code == OP_ABS),
    .use_carry (op_code == OP_ADDC),
    .a         (opa),
    .b         (opb),
    .cin       (carry_in),
    .res       (ar_res),
    .cout      (ar_c),
    .ovf       (ar_v)
  );

  ialu_logic #(.W(W)) u_logic (
    .invert_b (op_code == OP_ANDN),
    .a        (opa),
    .b        (opb),
    .res      (lg_res)
  );

  ialu_shift #(.W(W), .CW(CW)) u_shift (
    .val  (opa),
    .cnt  (opb[CW-1:0]),
    .res  (sh_res),
    .cout (sh_c)
  );

  always_comb begin
    nxt_res = '0;
    nxt_f   = '0;
    case (op_code)
      OP_ABS, OP_ADD, OP_ADDC: begin
        nxt_res = ar_res;
        nxt_f.c = ar_c;
        nxt_f.v = ar_v;
      end
      OP_AND, OP_ANDN: nxt_res = lg_res;
      OP_SHIFT: begin
        nxt_res = sh_res;
        nxt_f.c = sh_c;
      end
      default: nxt_res = '0;
    endcase
    nxt_f.n = nxt_res[W-1];
    nxt_f.z = (nxt_res == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      {flag_n, flag_z, flag_c, flag_v} <= 4'b0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        {flag_n, flag_z, flag_c, flag_v} <= nxt_f;
      end
    end
  end

  assert_valid_lat_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));

  assert_logic_flags_R6: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && (op_code == OP_AND || op_code == OP_ANDN))
      |-> (!flag_c && !flag_v));

  assert_abs_min_R3: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && op_code == OP_ABS && opb == MOST_NEG)
      |-> (flag_v && result == MOST_NEG));

  assert_unused_op_R10: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !rst && op_code[2:1] == 2'b11)
      |-> (result == '0 && flag_z && !flag_n && !flag_c && !flag_v));

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!in_valid && !rst) |-> $stable(result));
endmodule

// File: tb/test_ialu_core.sv
`timescale 1ns/1ps
module test_ialu_core;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  op_code;
  logic        three_op;
  logic [31:0] dst_val, src_a, src_b;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ialu_core i_ialu_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
    .three_op(three_op), .dst_val(dst_val), .src_a(src_a), .src_b(src_b),
    .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // expected {result, n, z, c, v}
  function automatic logic [35:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic ci);
    logic [31:0] r;
    logic c, v;
    longint s;
    int cnt;
    r = 0; c = 0; v = 0;
    case (op)
      3'd0: begin
        if (b == 32'h8000_0000) begin r = b; v = 1; end
        else r = b[31] ? 32'(-$signed(b)) : b;
      end
      3'd1, 3'd2: begin
        s = longint'($signed(a)) + longint'($signed(b)) + ((op == 3'd2 && ci) ? 1 : 0);
        r = s[31:0];
        v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        c = ({32'b0, a} + {32'b0, b} + ((op == 3'd2 && ci) ? 64'd1 : 64'd0)) >> 32 != 0;
      end
      3'd3: r = a & b;
      3'd4: r = a & ~b;
      3'd5: begin
        cnt = int'($signed(b[6:0]));
        r = a;
        if (cnt >= 0) begin
          for (int i = 0; i < cnt; i++) begin c = r[31]; r = r << 1; end
        end else begin
          for (int i = 0; i < -cnt; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
        end
      end
      default: r = 0;
    endcase
    return {r, r[31], (r == 0), c, v};
  endfunction

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] op, input logic t3,
                       input logic [31:0] d, input logic [31:0] a, input logic [31:0] b,
                       input logic ci);
    logic [35:0] exp;
    @(negedge clk);
    op_code = op; three_op = t3; dst_val = d; src_a = a; src_b = b; carry_in = ci;
    in_valid = 1'b1;
    exp = t3 ? model(op, a, b, ci) : model(op, d, a, ci);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {35'b0, out_valid}, 36'd1);
    check(tag, {result, flag_n, flag_z, flag_c, flag_v}, exp);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    logic [35:0] held;
    void'($urandom(32'd12345));
    rst = 1'b1; in_valid = 0; op_code = 0; three_op = 0;
    dst_val = 0; src_a = 0; src_b = 0; carry_in = 0;
    repeat (3) @(negedge clk);
    check("R11 reset", {out_valid, result, flag_n, flag_z, flag_c, flag_v}, 37'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after release", {out_valid, result, flag_n, flag_z, flag_c, flag_v}, 37'd0);

    apply("R3 abs neg", 3'd0, 0, 32'h0, 32'hFFFF_FFF6, 32'h0, 0);
    apply("R3 abs min", 3'd0, 0, 32'h0, 32'h8000_0000, 32'h0, 0);
    apply("R2 R3 abs three-op", 3'd0, 1, 32'h0, 32'h0, 32'h8000_0001, 0);
    apply("R4 add overflow", 3'd1, 0, 32'h7FFF_FFFF, 32'h1, 32'h0, 1);
    apply("R4 add carry", 3'd1, 1, 32'h0, 32'hFFFF_FFFF, 32'h1, 0);
    apply("R5 addc ripple", 3'd2, 0, 32'hFFFF_FFFF, 32'h0, 32'h0, 1);
    apply("R5 addc three-op", 3'd2, 1, 32'h5, 32'h10, 32'h20, 1);
    apply("R6 and", 3'd3, 0, 32'hF0F0_FFFF, 32'hFF00_00F0, 32'h0, 1);
    apply("R6 andn", 3'd4, 1, 32'h0, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 1);
    apply("R9 andn zero", 3'd4, 0, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0, 0);
    apply("R8 shift zero count", 3'd5, 0, 32'h8000_0001, 32'h0, 32'h0, 0);
    apply("R7 shift left 31", 3'd5, 1, 32'h0, 32'h0000_0003, 32'd31, 0);
    apply("R8 shift left 32", 3'd5, 1, 32'h0, 32'h0000_0001, 32'd32, 0);
    apply("R8 shift left 40", 3'd5, 1, 32'h0, 32'hFFFF_FFFF, 32'd40, 0);
    apply("R7 shift left 63", 3'd5, 1, 32'h0, 32'hFFFF_FFFF, 32'h3F, 0);
    apply("R7 shift right 1", 3'd5, 1, 32'h0, 32'h8000_0003, 32'h7F, 0);
    apply("R8 shift right 32", 3'd5, 1, 32'h0, 32'h8000_0000, 32'h60, 0);
    apply("R8 shift right 33", 3'd5, 1, 32'h0, 32'h8000_0000, 32'h5F, 0);
    apply("R7 shift right 64", 3'd5, 0, 32'h4000_0000, 32'h40, 32'h0, 0);
    apply("R10 opcode 6", 3'd6, 0, 32'h1, 32'h1, 32'h1, 1);
    apply("R10 opcode 7", 3'd7, 1, 32'hF, 32'hF, 32'hF, 1);

    // R1: idle cycles keep result and drop the strobe
    apply("R1 seed", 3'd1, 1, 32'h0, 32'h8000_0000, 32'h8000_0000, 0);
    held = {result, flag_n, flag_z, flag_c, flag_v};
    dst_val = 32'hDEAD_BEEF; src_a = 32'h1; op_code = 3'd1;
    repeat (2) begin
      @(negedge clk);
      check("R1 idle valid", {35'b0, out_valid}, 36'd0);
      check("R1 idle hold", {result, flag_n, flag_z, flag_c, flag_v}, held);
    end

    for (int k = 0; k < 3000; k++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      apply("R9 random", op, 1'($urandom), pick(), pick(), pick(), 1'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule